// File: doc/BRIEF.md
# Halt Mode Wake-Up Controller

This block sits beside a CPU core and owns its low-power halt state. When the core signals halt entry, the block captures the selected depth and holds it. There are three depths: a light idle with every peripheral clock running, a medium idle where only the always-on wake group is clocked, and a full stop with every group gated. While halted, the block watches the prioritised interrupt request, the non-maskable request and a small set of wake-only sources, and decides whether and how the core resumes.

A wake that comes from the non-maskable request, or from a maskable request whose level is above the current mask, resumes the core with the service flag set, so the interrupt is taken. A wake-only source (key, real-time clock, alarm) ends the halt even when its level is masked. In that case the core resumes at the next instruction without servicing it, and the source keeps its own pending flag. Leaving full stop, and coming out of reset, both pass through a settling window of 2^SETTLE_LOG2 clocks while the oscillator stabilises, with every clock group off.

The wake pulse and the service flag are registered outputs. They appear on the same edge that returns the state to RUN.

Top module: `halt_wake_ctrl`

## Requirements
- R1: With state RUN, a `halt_req_i` pulse moves `state_o` at the next edge by `halt_mode_i`: 2'b11 to IDLE2, 2'b10 to IDLE1, 2'b01 to STOP, and the reserved 2'b00 to IDLE2. The `state_o` codes are RUN=0, STOP=1, IDLE1=2, IDLE2=3, SETTLE=4.
- R2: In IDLE1 or IDLE2, a request with `irq_valid_i` high and `irq_level_i` strictly greater than `irq_mask_i` returns the state to RUN at the next edge, with `wake_o`=1 and `service_o`=1.
- R3: A maskable request whose level is less than or equal to the mask leaves the halt state unchanged and raises no `wake_o`.
- R4: `nmi_i` ends any halt mode whatever the mask, and the resulting wake carries `service_o`=1.
- R5: Any bit of `wake_src_i` (bit0 key, bit1 RTC, bit2 alarm) ends the halt even under a full mask. When no serviced cause is present at the same time, the wake carries `service_o`=0.
- R6: `wake_o` is high for exactly one cycle, only in the cycle where `state_o` has just become RUN, and `service_o` is never high without `wake_o`.
- R7: In STOP, a maskable request wakes the block only if `irq_async_i` is also high. Otherwise it is ignored.
- R8: A wake in STOP moves the state to SETTLE for exactly 2^SETTLE_LOG2 cycles. The state then becomes RUN with `wake_o`=1 and the `service_o` decided at the wake.
- R9: `rst_ni` low forces SETTLE at once with all clock enables off. After release the state becomes RUN after 2^SETTLE_LOG2 edges, with no `wake_o`.
- R10: `clk_en_o` is all ones in RUN and IDLE2, only bit0 in IDLE1, and zero in STOP and SETTLE.
- R11: `halt_req_i` while halted, and any request during SETTLE, leave the state and the settling count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| halt_mode_i | input | 2 | Halt depth selection |
| halt_req_i | input | 1 | Halt entry strobe from the core |
| irq_valid_i | input | 1 | A maskable request is pending |
| irq_level_i | input | LVL_W | Level of the highest pending maskable request |
| irq_async_i | input | 1 | Pending request comes from an asynchronous external pin |
| irq_mask_i | input | LVL_W | Current interrupt mask level |
| nmi_i | input | 1 | Non-maskable request |
| wake_src_i | input | NUM_WAKE | Wake-only sources: key, RTC, alarm |
| state_o | output | 3 | Current halt state code |
| clk_en_o | output | NUM_GRP | Peripheral group clock enables, bit0 is the wake group |
| wake_o | output | 1 | One-cycle resume pulse |
| service_o | output | 1 | The resume must take the interrupt |

## Verification
The wake decision is tried with a request below the mask, one equal to it and one above it, so the strict comparison is separated from a greater-or-equal one. A wake-only source under a full mask is set against a non-maskable request under the same mask, which separates resume-without-service from a serviced wake. In STOP, the same unmasked request is given with and without the asynchronous-pin flag, which shows that the stop filter is applied. The settling window is timed cycle by cycle after both reset and a STOP wake, so an off-by-one in the count shows up as a wrong state in a single cycle.

// File: rtl/halt_wake_pkg.sv
package halt_wake_pkg;

  typedef enum logic [2:0] {
    HS_RUN    = 3'd0,
    HS_STOP   = 3'd1,
    HS_IDLE1  = 3'd2,
    HS_IDLE2  = 3'd3,
    HS_SETTLE = 3'd4
  } hstate_e;

  // reserved code 2'b00 falls back to the lightest idle
  function automatic hstate_e decode_mode(input logic [1:0] mode);
    case (mode)
      2'b01:   return HS_STOP;
      2'b10:   return HS_IDLE1;
      default: return HS_IDLE2;
    endcase
  endfunction

endpackage

// File: rtl/hw_wake_qualify.sv
module hw_wake_qualify
  import halt_wake_pkg::*;
#(
  parameter int unsigned LVL_W    = 3,
  parameter int unsigned NUM_WAKE = 3
) (
  input  hstate_e             state_i,
  input  logic                irq_valid_i,
  input  logic [LVL_W-1:0]    irq_level_i,
  input  logic                irq_async_i,
  input  logic [LVL_W-1:0]    irq_mask_i,
  input  logic                nmi_i,
  input  logic [NUM_WAKE-1:0] wake_src_i,
  output logic                wake_any_o,
  output logic                service_o
);

  logic in_stop, lvl_ok, mask_ok, special;

  assign in_stop = (state_i == HS_STOP);
  assign lvl_ok  = irq_level_i > irq_mask_i;
  // in stop only pin-sourced requests can reach the wake logic
  assign mask_ok = irq_valid_i && lvl_ok && (!in_stop || irq_async_i);
  assign special = |wake_src_i;

  assign service_o  = nmi_i || mask_ok;
  assign wake_any_o = service_o || special;

endmodule

// File: rtl/hw_settle_timer.sv
module hw_settle_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (run_i && !done_o) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (&cnt_q);

endmodule

// File: rtl/hw_clk_gate_map.sv
module hw_clk_gate_map
  import halt_wake_pkg::*;
#(
  parameter int unsigned NUM_GRP = 4
) (
  input  hstate_e            state_i,
  output logic [NUM_GRP-1:0] en_o
);

  logic full_on, wake_on;

  assign full_on = (state_i == HS_RUN) || (state_i == HS_IDLE2);
  assign wake_on = full_on || (state_i == HS_IDLE1);

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    if (g == 0) begin : g_wake
      assign en_o[g] = wake_on;
    end else begin : g_periph
      assign en_o[g] = full_on;
    end
  end

endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl
  import halt_wake_pkg::*;
#(
  parameter int unsigned SETTLE_LOG2 = 8,
  parameter int unsigned LVL_W       = 3,
  parameter int unsigned NUM_WAKE    = 3,
  parameter int unsigned NUM_GRP     = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          halt_mode_i,
  input  logic                halt_req_i,
  input  logic                irq_valid_i,
  input  logic [LVL_W-1:0]    irq_level_i,
  input  logic                irq_async_i,
  input  logic [LVL_W-1:0]    irq_mask_i,
  input  logic                nmi_i,
  input  logic [NUM_WAKE-1:0] wake_src_i,
  output logic [2:0]          state_o,
  output logic [NUM_GRP-1:0]  clk_en_o,
  output logic                wake_o,
  output logic                service_o
);

  hstate_e st_q, st_d;
  logic    wake_q, wake_d, svc_q, svc_d;
  logic    from_rst_q, from_rst_d, svc_hold_q, svc_hold_d;
  logic    wk_any, wk_svc, tmr_clr, tmr_done;

  hw_wake_qualify #(.LVL_W(LVL_W), .NUM_WAKE(NUM_WAKE)) u_qual (
    .state_i     (st_q),
    .irq_valid_i (irq_valid_i),
    .irq_level_i (irq_level_i),
    .irq_async_i (irq_async_i),
    .irq_mask_i  (irq_mask_i),
    .nmi_i       (nmi_i),
    .wake_src_i  (wake_src_i),
    .wake_any_o  (wk_any),
    .service_o   (wk_svc)
  );

  hw_settle_timer #(.CNT_W(SETTLE_LOG2)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (tmr_clr),
    .run_i  (st_q == HS_SETTLE),
    .done_o (tmr_done)
  );

  hw_clk_gate_map #(.NUM_GRP(NUM_GRP)) u_gate (
    .state_i (st_q),
    .en_o    (clk_en_o)
  );

  always_comb begin
    st_d       = st_q;
    wake_d     = 1'b0;
    svc_d      = 1'b0;
    from_rst_d = from_rst_q;
    svc_hold_d = svc_hold_q;
    tmr_clr    = 1'b0;
    unique case (st_q)
      HS_RUN: begin
        if (halt_req_i) st_d = decode_mode(halt_mode_i);
      end
      HS_IDLE1, HS_IDLE2: begin
        if (wk_any) begin
          st_d   = HS_RUN;
          wake_d = 1'b1;
          svc_d  = wk_svc;
        end
      end
      HS_STOP: begin
        if (wk_any) begin
          st_d       = HS_SETTLE;
          tmr_clr    = 1'b1;
          from_rst_d = 1'b0;
          svc_hold_d = wk_svc;
        end
      end
      HS_SETTLE: begin
        // settling after reset resumes silently
        if (tmr_done) begin
          st_d       = HS_RUN;
          wake_d     = !from_rst_q;
          svc_d      = !from_rst_q && svc_hold_q;
          from_rst_d = 1'b0;
        end
      end
      default: st_d = HS_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= HS_SETTLE;
      wake_q     <= 1'b0;
      svc_q      <= 1'b0;
      from_rst_q <= 1'b1;
      svc_hold_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      wake_q     <= wake_d;
      svc_q      <= svc_d;
      from_rst_q <= from_rst_d;
      svc_hold_q <= svc_hold_d;
    end
  end

  assign state_o   = st_q;
  assign wake_o    = wake_q;
  assign service_o = svc_q;

endmodule

// File: rtl/halt_wake_chk.sv
module halt_wake_chk
  import halt_wake_pkg::*;
#(
  parameter int unsigned LVL_W    = 3,
  parameter int unsigned NUM_WAKE = 3,
  parameter int unsigned NUM_GRP  = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [1:0]          halt_mode_i,
  input logic                halt_req_i,
  input logic                irq_valid_i,
  input logic [LVL_W-1:0]    irq_level_i,
  input logic                irq_async_i,
  input logic [LVL_W-1:0]    irq_mask_i,
  input logic                nmi_i,
  input logic [NUM_WAKE-1:0] wake_src_i,
  input logic [2:0]          state_o,
  input logic [NUM_GRP-1:0]  clk_en_o,
  input logic                wake_o,
  input logic                service_o
);

  logic idle, unmasked, special;
  assign idle     = (state_o == HS_IDLE1) || (state_o == HS_IDLE2);
  assign unmasked = irq_valid_i && (irq_level_i > irq_mask_i);
  assign special  = |wake_src_i;

  AST_STOP_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == HS_RUN && halt_req_i && halt_mode_i == 2'b01) |=> state_o == HS_STOP); // R1
  AST_UNMASKED_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && unmasked) |=> (wake_o && service_o && state_o == HS_RUN)); // R2
  AST_MASKED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && !unmasked && !nmi_i && !special) |=> (!wake_o && $stable(state_o))); // R3
  AST_NMI_SERVICED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && nmi_i) |=> (wake_o && service_o)); // R4
  AST_SPECIAL_NO_SERVICE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && special && !nmi_i && !unmasked) |=> (wake_o && !service_o)); // R5
  AST_WAKE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o); // R6
  AST_WAKE_IN_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (state_o == HS_RUN && $past(state_o) != HS_RUN)); // R6
  AST_SERVICE_NEEDS_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    service_o |-> wake_o); // R6
  AST_STOP_SYNC_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == HS_STOP && !irq_async_i && !nmi_i && !special) |=> state_o == HS_STOP); // R7
  AST_STOP_VIA_SETTLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == HS_STOP) |=> (state_o == HS_STOP || state_o == HS_SETTLE)); // R8
  AST_GATED_DEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == HS_STOP || state_o == HS_SETTLE) |-> clk_en_o == '0); // R10
  AST_IDLE1_WAKE_GRP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == HS_IDLE1) |-> clk_en_o == NUM_GRP'(1)); // R10

endmodule

bind halt_wake_ctrl halt_wake_chk #(
  .LVL_W(LVL_W), .NUM_WAKE(NUM_WAKE), .NUM_GRP(NUM_GRP)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .halt_mode_i (halt_mode_i),
  .halt_req_i  (halt_req_i),
  .irq_valid_i (irq_valid_i),
  .irq_level_i (irq_level_i),
  .irq_async_i (irq_async_i),
  .irq_mask_i  (irq_mask_i),
  .nmi_i       (nmi_i),
  .wake_src_i  (wake_src_i),
  .state_o     (state_o),
  .clk_en_o    (clk_en_o),
  .wake_o      (wake_o),
  .service_o   (service_o)
);

// File: tb/tb_halt_wake_ctrl.sv
module tb_halt_wake_ctrl;
  localparam int unsigned LOG2 = 5;
  localparam int unsigned SETTLE = 1 << LOG2;

  localparam logic [2:0] S_RUN = 3'd0, S_STOP = 3'd1, S_IDLE1 = 3'd2, S_IDLE2 = 3'd3, S_SETTLE = 3'd4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       hreq = 1'b0, iv = 1'b0, asy = 1'b0, nmi = 1'b0;
  logic [2:0] lvl = '0, msk = '0, ws = '0;
  logic [2:0] state_o;
  logic [3:0] clk_en_o;
  logic       wake_o, service_o;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [8:0] exp_q[$];
  int         tag_q[$];

  always #5 clk = ~clk;

  halt_wake_ctrl #(.SETTLE_LOG2(LOG2), .LVL_W(3), .NUM_WAKE(3), .NUM_GRP(4)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .halt_mode_i(mode), .halt_req_i(hreq),
    .irq_valid_i(iv), .irq_level_i(lvl), .irq_async_i(asy), .irq_mask_i(msk),
    .nmi_i(nmi), .wake_src_i(ws), .state_o(state_o), .clk_en_o(clk_en_o),
    .wake_o(wake_o), .service_o(service_o)
  );

  function automatic logic [3:0] en_of(input logic [2:0] s);
    if (s == S_RUN || s == S_IDLE2) return 4'b1111;
    if (s == S_IDLE1) return 4'b0001;
    return 4'b0000;
  endfunction

  task automatic check(input int req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d: got state=%0d wake=%b svc=%b en=%b, want state=%0d wake=%b svc=%b en=%b",
               req, act[8:6], act[5], act[4], act[3:0], exp[8:6], exp[5], exp[4], exp[3:0]);
    end
  endtask

  task automatic clear_in();
    hreq = 0; iv = 0; asy = 0; nmi = 0; lvl = '0; msk = '0; ws = '0;
  endtask

  // driver: push expected outputs after the next edge, then move on
  task automatic tick(input int req, input logic [2:0] s, input logic w, input logic v);
    exp_q.push_back({s, w, v, en_of(s)});
    tag_q.push_back(req);
    @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [8:0] e;
        int t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {state_o, wake_o, service_o, clk_en_o}, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout, want completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic stop_settle(input int req, input logic v);
    // entry edge already expected SETTLE; 2^N-1 more, then RUN
    for (int i = 0; i < SETTLE - 1; i++) tick(req, S_SETTLE, 0, 0);
    tick(req, S_RUN, 1, v);
  endtask

  initial begin
    #12;
    check(9, {state_o, wake_o, service_o, clk_en_o}, {S_SETTLE, 1'b0, 1'b0, 4'b0000}); // R9 reset state
    @(negedge clk);
    rst_ni = 1;
    nmi = 1;  // R11 ignored while settling from reset
    for (int i = 0; i < SETTLE - 1; i++) tick(9, S_SETTLE, 0, 0);
    nmi = 0;
    tick(9, S_RUN, 0, 0);                        // R9 silent resume
    tick(10, S_RUN, 0, 0);                       // R10 all on in run

    // IDLE2 path
    mode = 2'b11; hreq = 1; tick(1, S_IDLE2, 0, 0);   // R1
    clear_in(); iv = 1; lvl = 3'd2; msk = 3'd3; tick(3, S_IDLE2, 0, 0);  // R3 below
    lvl = 3'd3; tick(3, S_IDLE2, 0, 0);                                  // R3 equal
    iv = 0; mode = 2'b01; hreq = 1; tick(11, S_IDLE2, 0, 0);             // R11
    clear_in(); iv = 1; lvl = 3'd5; msk = 3'd3; tick(2, S_RUN, 1, 1);   // R2
    clear_in(); tick(6, S_RUN, 0, 0);                                    // R6 single pulse

    // IDLE1 path
    mode = 2'b10; hreq = 1; tick(1, S_IDLE1, 0, 0);   // R1, R10
    clear_in(); tick(10, S_IDLE1, 0, 0);
    ws = 3'b001; msk = 3'd7; iv = 1; lvl = 3'd7; tick(5, S_RUN, 1, 0);  // R5 key wake
    clear_in(); tick(6, S_RUN, 0, 0);

    // reserved code
    mode = 2'b00; hreq = 1; tick(1, S_IDLE2, 0, 0);   // R1
    clear_in(); nmi = 1; msk = 3'd7; tick(4, S_RUN, 1, 1);               // R4
    clear_in(); tick(6, S_RUN, 0, 0);

    // STOP, special wake
    mode = 2'b01; hreq = 1; tick(1, S_STOP, 0, 0);    // R1, R10
    clear_in(); iv = 1; lvl = 3'd7; msk = 3'd0; tick(7, S_STOP, 0, 0); // R7 sync ignored
    clear_in(); ws = 3'b100; tick(8, S_SETTLE, 0, 0);                   // R8
    clear_in(); nmi = 1;                                                  // R11 ignored
    stop_settle(8, 0);
    clear_in(); tick(6, S_RUN, 0, 0);

    // STOP, async pin wake with service
    mode = 2'b01; hreq = 1; tick(1, S_STOP, 0, 0);
    clear_in(); iv = 1; asy = 1; lvl = 3'd1; msk = 3'd5; tick(7, S_STOP, 0, 0); // R7 masked pin
    lvl = 3'd4; msk = 3'd2; tick(7, S_SETTLE, 0, 0);                    // R7
    clear_in();
    stop_settle(8, 1);                                                    // R8
    clear_in(); tick(6, S_RUN, 0, 0);

    // reset while stopped
    mode = 2'b01; hreq = 1; tick(1, S_STOP, 0, 0);
    clear_in();
    @(posedge clk); #3;
    #1 rst_ni = 0; #1;
    check(9, {state_o, wake_o, service_o, clk_en_o}, {S_SETTLE, 1'b0, 1'b0, 4'b0000}); // R9
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule